// File: doc/BRIEF.md
# Nibble Serial Write Buffer

This block is a transmit-only serial port that sends data four bits at a time. Software writes a nibble into a holding register and sets a start control bit. The nibble then moves into an internal shift register, and its bits go out least significant first on a data line. They are qualified by a serial clock that idles low. The bit rate comes from one of four prescaler tap clocks. A two-bit select input chooses which tap is used, and the chip's prescaler supplies the taps.

Each time the holding register is emptied into the shifter, a buffer-empty flag rises. The same signal is the non-maskable interrupt request. Only a write to the holding register lowers this flag. Software can write the next nibble while the current one is still shifting. If that write arrives before the serial clock falls in the last bit, the next nibble follows without a gap, so a stream can be as long as needed. If no reload arrives in time, the busy bit clears itself at the end of the nibble. Clearing the start bit by software stops the transfer at once.

Top module: `nsw_tx`

## Requirements
- R1: The select value k (0 to 3) picks tap input bit k. While busy, each serial clock rising edge follows a rising edge of the selected tap, and each bit lasts exactly one tap period.
- R2: The serial clock is low whenever busy is low. The data output is low when idle. The data output changes only together with a serial clock rising edge and holds steady while the clock is high.
- R3: Within each nibble, bit 0 is sent first and bit 3 last.
- R4: A control write with the start value 1, made while idle and with the buffer holding a nibble written since the last transfer, raises busy and the empty flag on the next clock.
- R5: Every write to the buffer register clears the empty flag on the next clock.
- R6: A buffer write made before the serial clock falls in bit 3 is sent next. Its first serial clock rise comes exactly one tap period after the rise of the previous bit 3.
- R7: With no such reload, busy falls one tap period after the rise of bit 3, with no further serial clock pulse. A buffer write made after busy has fallen does not restart the transfer.
- R8: The empty flag stays high while the final nibble shifts and after the transfer ends, until a buffer write.
- R9: A start request made while the empty flag is high is ignored: busy stays low and the serial clock stays low.
- R10: A control write with the start value 0 while busy drops busy and the serial clock on the next clock, even in the middle of a nibble. No further serial clock pulses follow.
- R11: After reset, busy, the serial clock, the data output and the empty flag are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tap_i | input | 4 | Prescaler tap clocks, synchronous to clk, slowest at the top index |
| rate_sel_i | input | 2 | Tap index used as the bit rate |
| buf_we_i | input | 1 | Write strobe for the nibble buffer register |
| buf_wdata_i | input | 4 | Nibble written to the buffer |
| ctl_we_i | input | 1 | Write strobe for the start control bit |
| ctl_start_i | input | 1 | Start bit value written: 1 starts, 0 aborts |
| busy_o | output | 1 | Start bit readback, high while a transfer is active |
| empty_irq_o | output | 1 | Buffer-empty flag and non-maskable interrupt request |
| sclk_o | output | 1 | Serial clock, idle low |
| sdo_o | output | 1 | Serial data, least significant bit first |

## Verification
Suppose the shifter's bit counter or reload flag holds a wrong value. The first visible sign is a nibble that comes out mis-ordered or cut short. A serial clock gap of other than one tap period shows up at the very next bit boundary. A wrong buffer-full or empty state shows up as a start that is taken when it should be ignored, or refused when it should run. It can also show as an empty flag that drops without a write, visible within one clock of the event. Every select value is swept with a stream that walks through all sixteen nibble values. The bench measures each bit period in clock cycles against the tap period, which follows arithmetically from the tap index.

// File: rtl/nsw_pkg.sv
package nsw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_SHIFT = 2'd2
    } nsw_state_e;

    typedef struct packed {
        logic lvl;
        logic rise;
        logic fall;
    } tap_ev_t;

    function automatic int cnt_width(input int n);
        return (n > 2) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/nsw_tap_sel.sv
module nsw_tap_sel
    import nsw_pkg::*;
#(
    parameter int NTAP  = 4,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NTAP-1:0]  tap_i,
    input  logic [SEL_W-1:0] sel_i,
    output tap_ev_t          ev_o
);
    logic [NTAP-1:0] hit;
    logic            sel_lvl;
    logic            lvl_q;

    for (genvar g = 0; g < NTAP; g++) begin : g_tap
        assign hit[g] = tap_i[g] & (sel_i == SEL_W'(g));
    end

    assign sel_lvl = |hit;

    always_ff @(posedge clk) begin
        if (rst) lvl_q <= 1'b0;
        else     lvl_q <= sel_lvl;
    end

    assign ev_o.lvl  = lvl_q;
    assign ev_o.rise = sel_lvl & ~lvl_q;
    assign ev_o.fall = ~sel_lvl & lvl_q;
endmodule

// File: rtl/nsw_buf.sv
module nsw_buf #(
    parameter int NIB_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_i,
    input  logic [NIB_W-1:0] wdata_i,
    input  logic             take_i,
    output logic             avail_o,
    output logic [NIB_W-1:0] data_o,
    output logic             empty_o
);
    logic [NIB_W-1:0] hold_q;
    logic             full_q;
    logic             empty_q;

    assign avail_o = full_q | wr_i;
    assign data_o  = wr_i ? wdata_i : hold_q;
    assign empty_o = empty_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q  <= '0;
            full_q  <= 1'b0;
            empty_q <= 1'b0;
        end else if (take_i) begin
            full_q  <= 1'b0;
            empty_q <= 1'b1;
        end else if (wr_i) begin
            hold_q  <= wdata_i;
            full_q  <= 1'b1;
            empty_q <= 1'b0;
        end
    end

    // R4
    take_avail_chk: assert property (@(posedge clk) disable iff (rst)
        take_i |-> avail_o);

    // R5
    wr_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_i && !take_i) |=> !empty_o);
endmodule

// File: rtl/nsw_shift.sv
module nsw_shift
    import nsw_pkg::*;
#(
    parameter int NIB_W = 4,
    localparam int CNT_W = cnt_width(NIB_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  tap_ev_t          ev_i,
    input  logic             start_we_i,
    input  logic             start_val_i,
    input  logic             avail_i,
    input  logic [NIB_W-1:0] data_i,
    output logic             take_o,
    output logic             busy_o,
    output logic             sclk_o,
    output logic             sdo_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(NIB_W - 1);

    nsw_state_e       state_q;
    logic [NIB_W-1:0] sh_q;
    logic [NIB_W-1:0] nxt_q;
    logic             more_q;
    logic [CNT_W-1:0] cnt_q;

    logic last_bit, start_ok, abort, reload;

    assign last_bit = (cnt_q == LAST);
    assign start_ok = (state_q == ST_IDLE) & start_we_i & start_val_i & avail_i;
    assign abort    = (state_q != ST_IDLE) & start_we_i & ~start_val_i;
    assign reload   = (state_q == ST_SHIFT) & ev_i.fall & last_bit & ~more_q & avail_i;
    assign take_o   = start_ok | reload;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            sh_q    <= '0;
            nxt_q   <= '0;
            more_q  <= 1'b0;
            cnt_q   <= '0;
        end else if (abort) begin
            state_q <= ST_IDLE;
            more_q  <= 1'b0;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_ok) begin
                        sh_q    <= data_i;
                        cnt_q   <= '0;
                        state_q <= ST_ARMED;
                    end
                end
                ST_ARMED: begin
                    if (ev_i.rise) state_q <= ST_SHIFT;
                end
                ST_SHIFT: begin
                    if (reload) begin
                        nxt_q  <= data_i;
                        more_q <= 1'b1;
                    end
                    if (ev_i.rise) begin
                        if (!last_bit) begin
                            cnt_q <= cnt_q + CNT_W'(1);
                        end else if (more_q) begin
                            sh_q   <= nxt_q;
                            cnt_q  <= '0;
                            more_q <= 1'b0;
                        end else begin
                            cnt_q   <= '0;
                            state_q <= ST_IDLE;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy_o = (state_q != ST_IDLE);
    assign sclk_o = (state_q == ST_SHIFT) & ev_i.lvl;
    assign sdo_o  = (state_q == ST_SHIFT) & sh_q[cnt_q];

    // R2
    sdo_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (sclk_o && $past(sclk_o)) |-> $stable(sdo_o));

    // R10
    abort_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_we_i && !start_val_i) |=> (!busy_o && !sclk_o));

    // R7
    busy_end_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> ($past(ev_i.rise) || $past(start_we_i)));
endmodule

// File: rtl/nsw_tx.sv
module nsw_tx
    import nsw_pkg::*;
#(
    parameter int NTAP  = 4,
    parameter int NIB_W = 4,
    localparam int SEL_W = cnt_width(NTAP)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NTAP-1:0]  tap_i,
    input  logic [SEL_W-1:0] rate_sel_i,
    input  logic             buf_we_i,
    input  logic [NIB_W-1:0] buf_wdata_i,
    input  logic             ctl_we_i,
    input  logic             ctl_start_i,
    output logic             busy_o,
    output logic             empty_irq_o,
    output logic             sclk_o,
    output logic             sdo_o
);
    tap_ev_t          ev;
    logic             take;
    logic             avail;
    logic [NIB_W-1:0] buf_data;

    nsw_tap_sel #(.NTAP(NTAP), .SEL_W(SEL_W)) u_tap (
        .clk   (clk),
        .rst   (rst),
        .tap_i (tap_i),
        .sel_i (rate_sel_i),
        .ev_o  (ev)
    );

    nsw_buf #(.NIB_W(NIB_W)) u_buf (
        .clk     (clk),
        .rst     (rst),
        .wr_i    (buf_we_i),
        .wdata_i (buf_wdata_i),
        .take_i  (take),
        .avail_o (avail),
        .data_o  (buf_data),
        .empty_o (empty_irq_o)
    );

    nsw_shift #(.NIB_W(NIB_W)) u_shift (
        .clk         (clk),
        .rst         (rst),
        .ev_i        (ev),
        .start_we_i  (ctl_we_i),
        .start_val_i (ctl_start_i),
        .avail_i     (avail),
        .data_i      (buf_data),
        .take_o      (take),
        .busy_o      (busy_o),
        .sclk_o      (sclk_o),
        .sdo_o       (sdo_o)
    );

    // R9
    start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && ctl_we_i && ctl_start_i && empty_irq_o && !buf_we_i) |=> !busy_o);
endmodule

// File: tb/nsw_tx_tb_top.sv
module nsw_tx_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] pcnt = '0;
    logic [1:0] rate_sel = '0;
    logic       buf_we = 1'b0;
    logic [3:0] buf_wdata = '0;
    logic       ctl_we = 1'b0;
    logic       ctl_start = 1'b0;
    logic       busy, empty_irq, sclk, sdo;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) pcnt <= pcnt + 8'd1;

    nsw_tx dut_i (
        .clk         (clk),
        .rst         (rst),
        .tap_i       (pcnt[5:2]),
        .rate_sel_i  (rate_sel),
        .buf_we_i    (buf_we),
        .buf_wdata_i (buf_wdata),
        .ctl_we_i    (ctl_we),
        .ctl_start_i (ctl_start),
        .busy_o      (busy),
        .empty_irq_o (empty_irq),
        .sclk_o      (sclk),
        .sdo_o       (sdo)
    );

    int n_chk = 0, n_fail = 0;
    int cyc = 0, nrise = 0, last_rise = 0, fall_cyc = 0;
    int gap_bad = 0, sdo_bad = 0, exp_per = 8;
    logic bits [0:63];
    logic sclk_p = 1'b0, sdo_p = 1'b0, busy_p = 1'b0;

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (sclk && !sclk_p) begin
            if (nrise < 64) bits[nrise] = sdo;
            if (nrise > 0 && (cyc - last_rise) != exp_per) gap_bad = gap_bad + 1;
            last_rise = cyc;
            nrise = nrise + 1;
        end
        if (sclk && sclk_p && sdo != sdo_p) sdo_bad = sdo_bad + 1;
        if (!busy && busy_p) fall_cyc = cyc;
        if (!busy && (sclk || sdo)) sdo_bad = sdo_bad + 1;
        sclk_p = sclk;
        sdo_p  = sdo;
        busy_p = busy;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr_buf(input logic [3:0] v);
        @(negedge clk); #1;
        buf_we = 1'b1; buf_wdata = v;
        @(negedge clk); #1;
        buf_we = 1'b0;
    endtask

    task automatic ctl(input logic v);
        @(negedge clk); #1;
        ctl_we = 1'b1; ctl_start = v;
        @(negedge clk); #1;
        ctl_we = 1'b0;
    endtask

    task automatic clear_mon(input int sel);
        rate_sel = 2'(sel);
        exp_per  = 8 << sel;
        nrise = 0; gap_bad = 0; sdo_bad = 0;
    endtask

    task automatic run_stream(input int sel, input int seed);
        int nib [16];
        int drop;
        for (int i = 0; i < 16; i++) nib[i] = (seed + i * 5) % 16;
        clear_mon(sel);
        wr_buf(4'(nib[0]));
        chk("R5 write clears empty", int'(empty_irq), 0);
        ctl(1'b1);
        chk("R4 busy after start", int'(busy), 1);
        chk("R4 empty after start", int'(empty_irq), 1);
        for (int i = 1; i < 16; i++) begin
            wr_buf(4'(nib[i]));
            while (!empty_irq) begin @(negedge clk); #1; end
        end
        drop = 0;
        while (busy) begin
            if (!empty_irq) drop++;
            @(negedge clk); #1;
        end
        chk("R8 empty held during final nibble", drop, 0);
        chk("R8 empty held after end", int'(empty_irq), 1);
        chk("R1 rise count", nrise, 64);
        chk("R6 continuous bit period", gap_bad, 0);
        chk("R7 end one period after last rise", fall_cyc - last_rise, exp_per);
        chk("R2 sdo stable and idle low", sdo_bad, 0);
        for (int i = 0; i < 16; i++) begin
            int got = 0;
            for (int b = 0; b < 4; b++) got |= int'(bits[4*i+b]) << b;
            chk("R3 nibble order", got, nib[i]);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 rst = 1'b0;
        @(negedge clk); #1;
        // R11
        chk("R11 busy", int'(busy), 0);
        chk("R11 sclk", int'(sclk), 0);
        chk("R11 sdo", int'(sdo), 0);
        chk("R11 empty", int'(empty_irq), 0);

        for (int s = 0; s < 4; s++) run_stream(s, 3 * s + 1);

        // R9: flag still set, start must be ignored
        clear_mon(0);
        ctl(1'b1);
        repeat (40) @(negedge clk);
        #1;
        chk("R9 busy stays low", int'(busy), 0);
        chk("R9 no sclk", nrise, 0);

        // R7: single nibble, late write does not restart
        clear_mon(1);
        wr_buf(4'hA);
        ctl(1'b1);
        while (busy) begin @(negedge clk); #1; end
        chk("R7 single nibble rises", nrise, 4);
        wr_buf(4'h3);
        chk("R5 late write clears empty", int'(empty_irq), 0);
        repeat (60) @(negedge clk);
        #1;
        chk("R7 no restart busy", int'(busy), 0);
        chk("R7 no restart sclk", nrise, 4);

        // R10: abort mid nibble
        clear_mon(0);
        ctl(1'b1);
        chk("R4 restart after write", int'(busy), 1);
        while (nrise < 2) begin @(negedge clk); #1; end
        ctl(1'b0);
        chk("R10 busy dropped", int'(busy), 0);
        chk("R10 sclk dropped", int'(sclk), 0);
        repeat (40) @(negedge clk);
        #1;
        chk("R10 no further clocks", nrise, 2);
        chk("R2 idle outputs", sdo_bad, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule